// File: doc/BRIEF.md
# Linear S-box Coefficient Expander

The block turns one seed table of linear S-box coefficients into a whole family of position-dependent tables. The seed holds the eight 8-bit coefficients for position 0. Each later position, 1 through 7, is built from the position before it by a fixed recurrence. That recurrence uses a byte shift whose new low bit is the XOR of the old top two bits. The finished family of 64 coefficient bytes is presented as one flat bus, so that a serial security latch can pick the table for each bit position.

The seed enters through a valid/ready handshake. A transfer happens on a rising clock edge where `seed_valid` and `seed_ready` are both high. After that edge, `seed_ready` stays low while the engine derives one position per clock. While ready is low, the upstream side must hold off: any seed it presents then is not taken and has no effect. `seed_ready` returns high in the same cycle that `done` rises, so the next seed can follow at once. The output table is plain state with no handshake. It is valid whenever `done` is high, and it does not change until the next accepted seed.

Top module: `lsx_expander`

## Requirements
- R1: After reset, `done` is 0, `seed_ready` is 1 and `coef_out` is all zeros.
- R2: A seed is taken only on an edge where `seed_valid` and `seed_ready` are both high. From that edge until `done` rises, `seed_ready` is low, and any seed presented in that window is ignored.
- R3: Coefficient b of position p sits at `coef_out[p*64 + b*8 +: 8]`. Seed coefficient b sits at `seed_data[b*8 +: 8]`. Position 0 equals the accepted seed from the cycle after acceptance.
- R4: The shift S maps bits x7..x0 to x6..x0 followed by a new bit 0 equal to x7^x6. For b = 1..6, c[p,b] = S(c[p-1,b-1]), and c[p,0] = S(c[p-1,7]).
- R5: The last coefficient is c[p,7] = S(c[p-1,6]) ^ S(c[p-1,7]), which is the same as S(c[p-1,6]) ^ c[p,0].
- R6: `done` is cleared by the accepting edge and rises on the 7th rising edge after it.
- R7: While `done` is high and no seed is accepted, `coef_out` holds its value.
- R8: `seed_ready` is high in the first cycle that `done` is high, so a new seed may be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_valid | input | 1 | Seed table offered |
| seed_ready | output | 1 | Engine idle and able to take a seed |
| seed_data | input | 64 | Position-0 coefficients, coefficient b at bits b*8+7..b*8 |
| done | output | 1 | All positions derived; table valid |
| coef_out | output | 512 | Full coefficient family, position p coefficient b at p*64+b*8 |

## Verification
Some properties are checked on every cycle. These are the handshake rules: ready falls after acceptance, done clears on acceptance, and ready is high once done is set. The checks also cover the exact seven-edge latency, the position-0 load, the hold of the table while idle, and the position-1 recurrence for coefficients 0 and 7 when done rises. The full 64-byte result for every position needs a reference expansion, so only the bench scenarios can show it. These scenarios cover random seeds, all-zero and all-ones seeds, single-bit seeds, seeds offered while busy, and back-to-back starts.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  typedef enum logic [0:0] {
    LSX_IDLE = 1'b0,
    LSX_RUN  = 1'b1
  } lsx_state_e;
endpackage

// File: rtl/lsx_step.sv
// Combinational derivation of one position's coefficient row from the previous row.
module lsx_step #(
  parameter int NCOEF = 8,
  parameter int CW    = 8,
  localparam int ROWW = NCOEF * CW
) (
  input  logic [ROWW-1:0] prev_row,
  output logic [ROWW-1:0] next_row
);
  logic [NCOEF-1:0][CW-1:0] prev_c;
  logic [NCOEF-1:0][CW-1:0] sh_c;
  logic [NCOEF-1:0][CW-1:0] next_c;

  assign prev_c = prev_row;

  // Shift every previous coefficient once; feedback bit = top two bits XORed.
  genvar gi;
  generate
    for (gi = 0; gi < NCOEF; gi++) begin : g_shift
      assign sh_c[gi] = {prev_c[gi][CW-2:0], prev_c[gi][CW-1] ^ prev_c[gi][CW-2]};
    end
  endgenerate

  // Rotate by one index; the last index folds in the wrap-around term.
  generate
    for (gi = 0; gi < NCOEF; gi++) begin : g_map
      if (gi == 0) begin : g_first
        assign next_c[gi] = sh_c[NCOEF-1];
      end else if (gi == NCOEF - 1) begin : g_last
        assign next_c[gi] = sh_c[NCOEF-2] ^ sh_c[NCOEF-1];
      end else begin : g_mid
        assign next_c[gi] = sh_c[gi-1];
      end
    end
  endgenerate

  assign next_row = next_c;
endmodule

// File: rtl/lsx_ctrl.sv
// Sequencer: accepts a seed, walks the write index over positions 1..NPOS-1.
module lsx_ctrl
  import lsx_pkg::*;
#(
  parameter int NPOS = 8,
  localparam int IW  = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed_valid,
  output logic          seed_ready,
  output logic          load_en,
  output logic          step_en,
  output logic [IW-1:0] wr_idx,
  output logic          done
);
  lsx_state_e state_q;
  logic [IW-1:0] idx_q;
  logic done_q;

  assign seed_ready = (state_q == LSX_IDLE);
  assign load_en    = seed_valid && seed_ready;
  assign step_en    = (state_q == LSX_RUN);
  assign wr_idx     = idx_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LSX_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (load_en) begin
        state_q <= LSX_RUN;
        idx_q   <= IW'(1);
        done_q  <= 1'b0;
      end else if (step_en) begin
        if (idx_q == IW'(NPOS - 1)) begin
          state_q <= LSX_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsx_table.sv
// Coefficient storage: one row per position, row 0 loaded from the seed.
module lsx_table #(
  parameter int NPOS  = 8,
  parameter int NCOEF = 8,
  parameter int CW    = 8,
  localparam int ROWW = NCOEF * CW,
  localparam int IW   = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [ROWW-1:0]      seed_row,
  input  logic                 step_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [ROWW-1:0]      new_row,
  output logic [ROWW-1:0]      prev_row,
  output logic [NPOS*ROWW-1:0] all_rows
);
  logic [NPOS-1:0][ROWW-1:0] tab_q;

  assign prev_row = tab_q[IW'(wr_idx - IW'(1))];
  assign all_rows = tab_q;

  genvar gp;
  generate
    for (gp = 0; gp < NPOS; gp++) begin : g_row
      if (gp == 0) begin : g_seed
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       tab_q[gp] <= '0;
          else if (load_en) tab_q[gp] <= seed_row;
        end
      end else begin : g_derived
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                      tab_q[gp] <= '0;
          else if (!load_en && step_en && wr_idx == IW'(gp)) tab_q[gp] <= new_row;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lsx_expander.sv
module lsx_expander #(
  parameter int NPOS  = 8,
  parameter int NCOEF = 8,
  parameter int CW    = 8,
  localparam int ROWW = NCOEF * CW,
  localparam int IW   = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seed_valid,
  output logic                 seed_ready,
  input  logic [ROWW-1:0]      seed_data,
  output logic                 done,
  output logic [NPOS*ROWW-1:0] coef_out
);
  logic          load_en;
  logic          step_en;
  logic [IW-1:0] wr_idx;
  logic [ROWW-1:0] prev_row;
  logic [ROWW-1:0] next_row;

  lsx_ctrl #(.NPOS(NPOS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_valid (seed_valid),
    .seed_ready (seed_ready),
    .load_en    (load_en),
    .step_en    (step_en),
    .wr_idx     (wr_idx),
    .done       (done)
  );

  lsx_step #(.NCOEF(NCOEF), .CW(CW)) u_step (
    .prev_row (prev_row),
    .next_row (next_row)
  );

  lsx_table #(.NPOS(NPOS), .NCOEF(NCOEF), .CW(CW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .seed_row (seed_data),
    .step_en  (step_en),
    .wr_idx   (wr_idx),
    .new_row  (next_row),
    .prev_row (prev_row),
    .all_rows (coef_out)
  );
endmodule

// File: rtl/lsx_expander_chk.sv
module lsx_expander_chk #(
  parameter int NPOS  = 8,
  parameter int NCOEF = 8,
  parameter int CW    = 8,
  localparam int ROWW = NCOEF * CW
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 seed_valid,
  input logic                 seed_ready,
  input logic [ROWW-1:0]      seed_data,
  input logic                 done,
  input logic [NPOS*ROWW-1:0] coef_out
);
  function automatic logic [CW-1:0] chk_shift(input logic [CW-1:0] x);
    return {x[CW-2:0], x[CW-1] ^ x[CW-2]};
  endfunction

  logic acc;
  assign acc = seed_valid && seed_ready;

  // Cycles since the last accepting edge, saturating.
  logic [4:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_q <= '0;
    else if (acc)                  since_q <= 5'd1;
    else if (since_q != 5'd0 && since_q != 5'd31) since_q <= since_q + 5'd1;
  end

  logic [CW-1:0] p0c6, p0c7, p1c0, p1c7;
  assign p0c6 = coef_out[(NCOEF-2)*CW +: CW];
  assign p0c7 = coef_out[(NCOEF-1)*CW +: CW];
  assign p1c0 = coef_out[ROWW +: CW];
  assign p1c7 = coef_out[ROWW + (NCOEF-1)*CW +: CW];

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !seed_ready);

  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_ready && !done) |-> since_q != 5'd0);

  a_r3_seed_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> coef_out[ROWW-1:0] == $past(seed_data));

  a_r4_first_coef: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> p1c0 == chk_shift(p0c7));

  a_r5_last_coef: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> p1c7 == (chk_shift(p0c6) ^ p1c0));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !done);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> since_q == 5'(NPOS));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> $stable(coef_out));

  a_r8_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> seed_ready);
endmodule

bind lsx_expander lsx_expander_chk #(.NPOS(NPOS), .NCOEF(NCOEF), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seed_valid (seed_valid),
  .seed_ready (seed_ready),
  .seed_data  (seed_data),
  .done       (done),
  .coef_out   (coef_out)
);

// File: tb/sim_lsx_expander.sv
`timescale 1ns/1ps
module sim_lsx_expander;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         seed_valid = 1'b0;
  logic         seed_ready;
  logic [63:0]  seed_data = '0;
  logic         done;
  logic [511:0] coef_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsx_expander u0 (
    .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_ready(seed_ready),
    .seed_data(seed_data), .done(done), .coef_out(coef_out)
  );

  function automatic logic [7:0] sh8(input logic [7:0] x);
    return {x[6:0], x[7] ^ x[6]};
  endfunction

  // Reference expansion from the written recurrence (R4, R5).
  function automatic logic [511:0] expand(input logic [63:0] s);
    logic [7:0] c [8][8];
    logic [511:0] r;
    for (int b = 0; b < 8; b++) c[0][b] = s[b*8 +: 8];
    for (int p = 1; p < 8; p++) begin
      for (int b = 0; b < 7; b++) c[p][b] = sh8(c[p-1][(b+7)%8]);
      c[p][7] = sh8(c[p-1][6]) ^ sh8(c[p-1][7]);
    end
    for (int p = 0; p < 8; p++)
      for (int b = 0; b < 8; b++) r[p*64 + b*8 +: 8] = c[p][b];
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Offer a seed, optionally pester with another seed while busy, verify timing and table.
  task automatic run_seed(input logic [63:0] s, input bit pester, input logic [63:0] junk);
    logic [511:0] exp_t;
    exp_t = expand(s);
    @(negedge clk);
    check("R2 ready before start", 512'(seed_ready), 512'(1));
    seed_valid = 1'b1;
    seed_data  = s;
    @(negedge clk);
    check("R2 ready low after accept", 512'(seed_ready), 512'(0));
    check("R6 done cleared on accept", 512'(done), 512'(0));
    check("R3 position 0 equals seed", 512'(coef_out[63:0]), 512'(s));
    if (pester) begin
      seed_data = junk;
    end else begin
      seed_valid = 1'b0;
    end
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (i < 7) check("R6 done not early", 512'(done), 512'(0));
      else       check("R6 done at edge 7", 512'(done), 512'(1));
    end
    seed_valid = 1'b0;
    check("R8 ready with done", 512'(seed_ready), 512'(1));
    check("R4 R5 full table", coef_out, exp_t);
    if (pester) check("R2 busy seed ignored", coef_out, exp_t);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset done", 512'(done), 512'(0));
    check("R1 reset ready", 512'(seed_ready), 512'(1));
    check("R1 reset table", coef_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_seed(64'h0, 0, '0);
    run_seed({8{8'hFF}}, 0, '0);
    run_seed(64'h0000_0000_0000_0001, 0, '0);
    run_seed(64'h8000_0000_0000_0000, 0, '0);
    run_seed(64'h0123_4567_89AB_CDEF, 1, 64'hDEAD_BEEF_0BAD_F00D);

    // R7: table holds while idle and valid low.
    held = coef_out;
    repeat (5) @(negedge clk);
    check("R7 table held idle", coef_out, held);

    for (int k = 0; k < 12; k++) begin
      logic [63:0] s;
      s = {$urandom(), $urandom()};
      run_seed(s, (k % 3) == 0, {$urandom(), $urandom()});
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule